// File: doc/BRIEF.md
# Multidrop-capable asynchronous serial receiver

This block recovers characters from a single asynchronous serial input and queues them for a host. The line is resynchronised, then oversampled against a tick supplied from outside; no baud-rate divider is included. Each recovered character carries 8 data bits, an optional ninth bit and a framing flag. It is pushed into a small first-in-first-out buffer that the host drains one entry per read pulse.

For multidrop buses the receiver can filter on the ninth bit. With the filter on, only address characters (ninth bit set) reach the buffer. The host reads the address, decides whether it is being spoken to, and turns the filter off to receive the data that follows. A buffer that fills and then receives one more character raises a sticky overrun condition. That condition blocks further loading until the host drops the receive enable.

Top module: `uart_addr_rx`

## Requirements
- R1: Characters are recovered only while port_en=1, sync_mode=0 and rx_en=1. Frames sent otherwise leave the buffer unchanged. While port_en=0 or sync_mode=1 the buffer is emptied.
- R2: A frame is one low start bit, then data bits least significant first, then one stop bit. The low 8 data bits appear on rd_data. With os_tick high on every clock (16 ticks per bit, two-stage input synchroniser), the character reaches the read outputs at the rising edge 13+16*(D+1) edges after the edge following which rxd fell. D is 8, or 9 when nine_bit=1.
- R3: With nine_bit=1 the ninth data bit is shown on rd_bit9, apart from rd_data. With nine_bit=0, rd_bit9 reads 0.
- R4: rd_ready rises when a character enters the buffer. irq is high exactly when rd_ready=1 and int_en=1.
- R5: With addr_det=1 and nine_bit=1, a character whose ninth bit is 0 is discarded. Only characters with the ninth bit 1 are loaded, so rd_bit9 reads 1 for them. With addr_det=0 every character is loaded.
- R6: The buffer holds two entries and is read oldest first. A one-cycle rd_pop removes the head. rd_ready stays high while any entry remains. rd_pop on an empty buffer has no effect.
- R7: A character that completes while both entries are full, with no pop in the same cycle, sets ovr_err and is dropped. While ovr_err=1 no character is loaded. A pop in the same cycle as an arrival at a full buffer frees a slot, so the arrival is loaded and no overrun occurs.
- R8: ovr_err stays set until rx_en is 0 at a clock edge, which clears it.
- R9: Each bit is decided by a majority of samples 7, 8 and 9 of its 16. A single wrong sample does not corrupt the bit. A low pulse that reads high at mid-start-bit is discarded as a glitch.
- R10: A stop bit decided low sets frm_err for that character. frm_err is stored with the entry and shown while the entry is at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| port_en | input | 1 | Serial port enable |
| sync_mode | input | 1 | Synchronous mode select (1 turns this receiver off) |
| rx_en | input | 1 | Receive enable; low clears overrun |
| nine_bit | input | 1 | Selects 9-bit frames |
| addr_det | input | 1 | Ninth-bit address filter enable |
| int_en | input | 1 | Receive interrupt enable |
| rd_pop | input | 1 | Read strobe, removes the head entry |
| rd_data | output | 8 | Head entry low data bits (0 when empty) |
| rd_bit9 | output | 1 | Head entry ninth bit |
| rd_ready | output | 1 | Buffer holds at least one entry |
| frm_err | output | 1 | Head entry framing error |
| ovr_err | output | 1 | Sticky overrun flag |
| irq | output | 1 | Receive interrupt |

## Verification
The delicate coincidence is a host read landing on the same edge as a new character arriving at a full buffer. That case separates a correct shift-and-refill from a false overrun. The bench fills both entries, then aims rd_pop at the exact edge the third character completes, computed from the frame timing. It judges the outcome every clock against a queue model: overrun stays clear, the second entry becomes the head, and the newcomer sits behind it. A second coincidence is the clearing of rx_en against a pending overrun. It is covered by holding overrun across pops and confirming it drops only on the disabled edge.

// File: rtl/uarx_pkg.sv
package uarx_pkg;
   typedef struct packed {
      logic [7:0] data;
      logic       bit9;
      logic       ferr;
   } rx_char_t;
endpackage

// File: rtl/uarx_sync.sv
module uarx_sync #(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("uarx_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/uarx_shifter.sv
module uarx_shifter
   import uarx_pkg::*;
#(
   parameter int OSR = 16
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     active,
   input  logic     tick,
   input  logic     rxs,
   input  logic     nine,
   output logic     done,
   output rx_char_t chr
);
   localparam int PW  = $clog2(OSR);
   localparam int MID = OSR / 2;

   generate
      if (OSR < 8) begin : g_bad_osr
         $error("uarx_shifter: OSR must be at least 8");
      end
   endgenerate

   typedef enum logic {S_IDLE, S_RUN} st_t;
   st_t            state;
   logic [PW-1:0]  phase;
   logic [3:0]     bit_idx;
   logic [3:0]     last_idx;
   logic [8:0]     sh;
   logic           s_a, s_b, vote;

   assign last_idx = nine ? 4'd10 : 4'd9;
   assign vote     = (s_a & s_b) | (s_a & rxs) | (s_b & rxs);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= S_IDLE;
         phase   <= '0;
         bit_idx <= '0;
         sh      <= '0;
         s_a     <= 1'b1;
         s_b     <= 1'b1;
         done    <= 1'b0;
         chr     <= '0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            state <= S_IDLE;
         end else if (tick) begin
            case (state)
               S_IDLE: begin
                  if (!rxs) begin
                     state   <= S_RUN;
                     phase   <= PW'(1);
                     bit_idx <= '0;
                  end
               end
               S_RUN: begin
                  phase <= (phase == PW'(OSR-1)) ? '0 : phase + 1'b1;
                  if (phase == PW'(OSR-1)) bit_idx <= bit_idx + 4'd1;
                  if (phase == PW'(MID-1)) s_a <= rxs;
                  if (phase == PW'(MID))   s_b <= rxs;
                  if (phase == PW'(MID+1)) begin
                     if (bit_idx == 4'd0) begin
                        if (vote) state <= S_IDLE;
                     end else if (bit_idx == last_idx) begin
                        done      <= 1'b1;
                        chr.ferr  <= ~vote;
                        chr.data  <= nine ? sh[7:0] : sh[8:1];
                        chr.bit9  <= nine & sh[8];
                        state     <= S_IDLE;
                     end else begin
                        sh <= {vote, sh[8:1]};
                     end
                  end
               end
               default: state <= S_IDLE;
            endcase
         end
      end
   end

   assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> state == S_IDLE);
   assert_inactive_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !active |=> (state == S_IDLE) && !done);
endmodule

// File: rtl/uarx_rxbuf.sv
module uarx_rxbuf
   import uarx_pkg::*;
#(
   parameter int DEPTH = 2
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     flush,
   input  logic     clr_ovr,
   input  logic     push,
   input  rx_char_t push_chr,
   input  logic     pop,
   output rx_char_t head,
   output logic     nonempty,
   output logic     ovr
);
   localparam int CW = $clog2(DEPTH + 1);

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("uarx_rxbuf: DEPTH must be at least 1");
      end
   endgenerate

   rx_char_t       mem [DEPTH];
   logic [CW-1:0]  cnt;
   logic [CW-1:0]  wr_slot;
   logic           pop_ok, full_eff, take, set_ovr;

   assign pop_ok   = pop && (cnt != '0);
   assign full_eff = (cnt == CW'(DEPTH)) && !pop_ok;
   assign take     = push && !ovr && !full_eff && !flush;
   assign set_ovr  = push && !ovr && full_eff && !flush;
   assign wr_slot  = cnt - CW'(pop_ok);

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      rx_char_t shifted;
      if (i < DEPTH - 1) begin : g_mid
         assign shifted = pop_ok ? mem[i+1] : mem[i];
      end else begin : g_last
         assign shifted = mem[i];
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            mem[i] <= '0;
         else if (take && wr_slot == CW'(i))    mem[i] <= push_chr;
         else                                   mem[i] <= shifted;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         ovr <= 1'b0;
      end else begin
         if (flush) cnt <= '0;
         else       cnt <= cnt - CW'(pop_ok) + CW'(take);
         if (clr_ovr)      ovr <= 1'b0;
         else if (set_ovr) ovr <= 1'b1;
      end
   end

   assign head     = mem[0];
   assign nonempty = (cnt != '0);

   assert_count_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CW'(DEPTH));
   assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !clr_ovr) |=> ovr);
   assert_ovr_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !clr_ovr && !flush) |=> cnt <= $past(cnt));
   assert_ovr_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $past(cnt) == CW'(DEPTH));

   generate
      if (DEPTH >= 2) begin : g_order_chk
         assert_pop_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (pop && cnt >= CW'(2) && !push && !flush) |=> head == $past(mem[1]));
      end
   endgenerate
endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx
   import uarx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int DEPTH       = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       rxd,
   input  logic       port_en,
   input  logic       sync_mode,
   input  logic       rx_en,
   input  logic       nine_bit,
   input  logic       addr_det,
   input  logic       int_en,
   input  logic       rd_pop,
   output logic [7:0] rd_data,
   output logic       rd_bit9,
   output logic       rd_ready,
   output logic       frm_err,
   output logic       ovr_err,
   output logic       irq
);
   logic     rx_s, active, addr_on, done, accept;
   rx_char_t chr, head;

   assign active  = port_en & ~sync_mode & rx_en;
   assign addr_on = addr_det & nine_bit;

   uarx_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s));

   uarx_shifter #(.OSR(OSR)) u_shift (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(os_tick),
      .rxs(rx_s), .nine(nine_bit), .done(done), .chr(chr));

   assign accept = done & ~(addr_on & ~chr.bit9);

   uarx_rxbuf #(.DEPTH(DEPTH)) u_buf (
      .clk(clk), .rst_n(rst_n), .flush(~port_en | sync_mode),
      .clr_ovr(~rx_en), .push(accept), .push_chr(chr), .pop(rd_pop),
      .head(head), .nonempty(rd_ready), .ovr(ovr_err));

   assign rd_data = rd_ready ? head.data : 8'h00;
   assign rd_bit9 = rd_ready & head.bit9;
   assign frm_err = rd_ready & head.ferr;
   assign irq     = rd_ready & int_en;

   assert_addr_filter_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(rd_ready) && $past(addr_on)) |-> rd_bit9);
endmodule

// File: tb/tb_uart_addr_rx.sv
module tb_uart_addr_rx;
   logic clk = 1'b0, rst_n = 1'b0;
   logic rxd = 1'b1, port_en = 1'b1, sync_mode = 1'b0, rx_en = 1'b1;
   logic nine_bit = 1'b0, addr_det = 1'b0, int_en = 1'b1;
   logic pop_man = 1'b0, pop_auto = 1'b0, rd_pop;
   logic [7:0] rd_data;
   logic rd_bit9, rd_ready, frm_err, ovr_err, irq;

   assign rd_pop = pop_man | pop_auto;
   always #2 clk = ~clk;

   uart_addr_rx dut (
      .clk(clk), .rst_n(rst_n), .os_tick(1'b1), .rxd(rxd), .port_en(port_en),
      .sync_mode(sync_mode), .rx_en(rx_en), .nine_bit(nine_bit), .addr_det(addr_det),
      .int_en(int_en), .rd_pop(rd_pop), .rd_data(rd_data), .rd_bit9(rd_bit9),
      .rd_ready(rd_ready), .frm_err(frm_err), .ovr_err(ovr_err), .irq(irq));

   typedef struct packed { logic [7:0] d; logic b9; logic fe; } ent_t;
   ent_t exp_q[$];
   int   ev_t[$];
   ent_t ev_c[$];
   int   cyc = 0, pop_auto_cyc = -1;
   int   n_chk = 0, n_err = 0;
   bit   ovr_m = 1'b0, finished = 1'b0;

   function automatic void chk(string tag, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
      end
   endfunction

   // reference model, updated on every rising edge
   always @(posedge clk) begin
      bit   pop_ok, have_ev;
      ent_t e;
      cyc++;
      have_ev = 1'b0;
      e = '0;
      if (!rst_n) begin
         exp_q.delete();
         ovr_m = 1'b0;
      end else begin
         while (ev_t.size() > 0 && ev_t[0] < cyc) begin
            void'(ev_t.pop_front()); void'(ev_c.pop_front());
         end
         if (ev_t.size() > 0 && ev_t[0] == cyc) begin
            have_ev = 1'b1; e = ev_c[0];
            void'(ev_t.pop_front()); void'(ev_c.pop_front());
         end
         pop_ok = rd_pop && exp_q.size() > 0;
         if (!port_en || sync_mode) exp_q.delete();
         else begin
            if (pop_ok) void'(exp_q.pop_front());
            if (have_ev && !(addr_det && nine_bit && !e.b9) && !ovr_m) begin
               if (exp_q.size() >= 2) ovr_m = 1'b1;
               else exp_q.push_back(e);
            end
         end
         if (!rx_en) ovr_m = 1'b0;
      end
   end

   always @(posedge clk) begin
      #1 pop_auto = (cyc + 1 == pop_auto_cyc);
   end

   // compare every clock, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         bit r;
         r = exp_q.size() > 0;
         chk("R6 ready", int'(rd_ready), int'(r));
         if (r) begin
            chk("R2 data", int'(rd_data), int'(exp_q[0].d));
            chk("R3 ninth bit", int'(rd_bit9), int'(exp_q[0].b9));
            chk("R10 framing", int'(frm_err), int'(exp_q[0].fe));
         end
         chk("R7 overrun", int'(ovr_err), int'(ovr_m));
         chk("R4 irq", int'(irq), int'(r && int_en));
      end
   end

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   // val: 9-bit payload; stop_hi: stop level; noise_bit: bit slot with one flipped sample
   task automatic send(logic [8:0] val, bit stop_hi = 1'b1, int noise_bit = -1,
                       bit pop_on_arrival = 1'b0);
      int   nb, t0;
      logic lvl;
      nb = nine_bit ? 9 : 8;
      @(posedge clk); #1;
      t0 = cyc;
      if (port_en && !sync_mode && rx_en) begin
         ev_t.push_back(t0 + 13 + 16 * (nb + 1));
         ev_c.push_back({val[7:0], nine_bit & val[8], ~stop_hi});
         if (pop_on_arrival) pop_auto_cyc = t0 + 13 + 16 * (nb + 1);
      end
      for (int i = 0; i < nb + 2; i++) begin
         lvl = (i == 0) ? 1'b0 : (i == nb + 1) ? stop_hi : val[i-1];
         for (int k = 0; k < 16; k++) begin
            rxd = (i == noise_bit && k == 8) ? ~lvl : lvl;
            @(posedge clk); #1;
         end
      end
      rxd = 1'b1;
      idle(24);
   endtask

   task automatic pop1();
      @(posedge clk); #1 pop_man = 1'b1;
      @(posedge clk); #1 pop_man = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=done");
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R6 reset ready", int'(rd_ready), 0);
      chk("R7 reset overrun", int'(ovr_err), 0);
      chk("R4 reset irq", int'(irq), 0);
      @(posedge clk); #1 rst_n = 1'b1;
      idle(5);

      // R2: two 8-bit characters, read oldest first
      send(9'h0A5); send(9'h03C);
      chk("R6 two entries, head", int'(rd_data), 8'hA5);
      pop1(); idle(1);
      chk("R6 second entry", int'(rd_data), 8'h3C);
      pop1(); idle(1);
      pop1(); idle(1);
      chk("R6 pop on empty", int'(rd_ready), 0);

      // R7/R8: overrun, sticky until rx_en drops
      send(9'h011); send(9'h022); send(9'h033);
      chk("R7 overrun set", int'(ovr_err), 1);
      send(9'h044);
      chk("R7 head kept", int'(rd_data), 8'h11);
      pop1(); pop1(); idle(2);
      chk("R8 overrun survives pops", int'(ovr_err), 1);
      send(9'h055);
      chk("R7 blocked while overrun", int'(rd_ready), 0);
      rx_en = 1'b0; idle(1); rx_en = 1'b1; idle(1);
      chk("R8 cleared by rx_en low", int'(ovr_err), 0);

      // R7: pop in the same cycle as a third arrival
      send(9'h0C1); send(9'h0C2); send(9'h0C3, 1'b1, -1, 1'b1);
      chk("R7 no overrun on simultaneous pop", int'(ovr_err), 0);
      chk("R7 head after simultaneous pop", int'(rd_data), 8'hC2);
      pop1(); pop1(); idle(2);

      // R3: 9-bit frames
      nine_bit = 1'b1;
      send(9'h155); send(9'h0AA);
      chk("R3 ninth bit set", int'(rd_bit9), 1);
      pop1(); idle(1);
      chk("R3 ninth bit clear", int'(rd_bit9), 0);
      pop1(); idle(1);

      // R5: address filter
      addr_det = 1'b1;
      send(9'h0AA);
      chk("R5 data char dropped", int'(rd_ready), 0);
      send(9'h1C3);
      chk("R5 address char loaded", int'(rd_data), 8'hC3);
      pop1(); addr_det = 1'b0; idle(1);
      send(9'h012);
      chk("R5 filter off loads all", int'(rd_data), 8'h12);
      pop1(); nine_bit = 1'b0; idle(1);

      // R10: framing error stored per entry
      send(9'h07E, 1'b0); send(9'h081);
      chk("R10 framing on head", int'(frm_err), 1);
      pop1(); idle(1);
      chk("R10 clean second entry", int'(frm_err), 0);
      pop1(); idle(1);

      // R9: start glitch and one bad sample in a data bit
      @(posedge clk); #1 rxd = 1'b0; idle(4); rxd = 1'b1; idle(40);
      chk("R9 glitch rejected", int'(rd_ready), 0);
      send(9'h0F0, 1'b1, 3); send(9'h00F, 1'b1, 6);
      chk("R9 vote head", int'(rd_data), 8'hF0);
      pop1(); pop1(); idle(2);

      // R1: gating
      rx_en = 1'b0; send(9'h066); rx_en = 1'b1; idle(1);
      chk("R1 rx_en low ignores", int'(rd_ready), 0);
      sync_mode = 1'b1; send(9'h067); sync_mode = 1'b0; idle(1);
      chk("R1 sync mode ignores", int'(rd_ready), 0);
      send(9'h068);
      port_en = 1'b0; idle(2);
      chk("R1 port off flushes", int'(rd_ready), 0);
      port_en = 1'b1; idle(2);

      // R4: interrupt masked
      int_en = 1'b0; send(9'h099);
      chk("R4 irq masked", int'(irq), 0);
      int_en = 1'b1; idle(1);
      chk("R4 irq enabled", int'(irq), 1);
      pop1(); idle(4);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule